// File: doc/BRIEF.md
# Parity Bit-Mask Write Merger

This block sits between a row-cycle memory controller and a byte-organized word store of `NUM_BYTES` lanes, each `LANE_W` bits wide. The top bit of every lane is a parity bit and the lower bits are data. When a row cycle opens with a mask request, the block takes a mask from the parity positions of the write-data bus. Those same pins then carry write data for the rest of the cycle. For every later write in that row cycle, only the parity bits whose mask bit is one are replaced. The data bits of a lane are replaced whenever that lane's column select is active. The mask has no effect on data bits.

Each write presents the current stored word and the new data. One cycle later the block returns the merged word with a write strobe, and the surrounding logic commits it to storage. A row cycle opened without a mask request writes every parity bit of the selected lanes. Closing the row clears the mask.

The control is a three-state machine. `ST_IDLE` means no row is open. `ST_OPEN_FULL` means a row is open with no masking. `ST_OPEN_MASKED` means a row is open with the captured mask in force. Three transitions connect them. T_OPEN_PLAIN goes from idle to full when `row_act` is seen high and `mask_req` is low. T_OPEN_MASK goes from idle to masked when `row_act` is seen high and `mask_req` is high. T_CLOSE goes from either open state back to idle when `row_act` is low. In every other case the state holds.

Top module: `par_bitmask_writer`

## Requirements
- R1: After reset, `write_stb` is 0 and `merged` is all zeros.
- R2: In the cycle where `row_act` is first seen high while idle and `mask_req` is high, the mask is taken from the parity positions of `wdata`. Bit b of the mask is `wdata[b*LANE_W + LANE_W-1]`. The data positions of `wdata` in that cycle have no effect on the mask.
- R3: During a write, a mask bit of 1 makes the parity bit of that lane come from `wdata`. A mask bit of 0 makes it come from `stored`. This applies only to selected lanes.
- R4: The data bits (`LANE_W-1` low bits) of a lane come from `wdata` exactly when that lane's `col_sel` bit is 1, whatever the mask.
- R5: A lane whose `col_sel` bit is 0 is copied from `stored` entirely, parity bit included.
- R6: A write takes place only when a row is open, `row_act` is high, `wr_en` is high and at least one `col_sel` bit is high. The result appears on `merged` with `write_stb` high one clock later. With `wr_en` high but no lane selected, no strobe is raised and `merged` is unchanged.
- R7: A captured mask stays in force for every write of the same row cycle.
- R8: Closing the row (`row_act` low while open) clears the mask. A row cycle opened without `mask_req` writes all parity bits of the selected lanes.
- R9: Write requests while idle, including the capture cycle, raise no strobe. `merged` holds its last value whenever no write takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_act | input | 1 | Row cycle active (high while the row strobe is asserted) |
| mask_req | input | 1 | Sampled at row open: take a parity mask from the bus |
| col_sel | input | NUM_BYTES | Per-lane column-latch select, active high |
| wr_en | input | 1 | Write enable, active high |
| wdata | input | NUM_BYTES*LANE_W | Write data; carries the mask on parity positions at row open |
| stored | input | NUM_BYTES*LANE_W | Current contents of the addressed word |
| merged | output | NUM_BYTES*LANE_W | Merged word to be committed |
| write_stb | output | 1 | High for one cycle when `merged` carries a new write result |

## Verification
The bench opens a masked row using a bus word whose data positions are the inverse of its parity positions. A design that took the mask from the wrong bits would then write the wrong parity lanes. It writes twice in one masked row with opposite data, so a mask that is lost after the first write, or one that leaks onto data bits, shows up as wrong data or parity. It asserts `wr_en` with no lane selected and also during the capture cycle, where a design that ignored the select or the pin sharing would raise a strobe and corrupt `merged`. Finally it closes a masked row and reopens a plain one, where a mask that was not cleared would keep parity bits from being written.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_OPEN_FULL   = 2'd1,
        ST_OPEN_MASKED = 2'd2
    } pbw_state_e;

endpackage

// File: rtl/pbw_row_fsm.sv
module pbw_row_fsm
    import pbw_pkg::*;
#(
    parameter int NUM_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 row_act,
    input  logic                 mask_req,
    input  logic                 wr_en,
    input  logic [NUM_BYTES-1:0] col_sel,
    output pbw_state_e           state_q,
    output logic                 cap_masked,
    output logic                 cap_plain,
    output logic                 close_row,
    output logic                 write_ok
);

    pbw_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (row_act && mask_req)  state_d = ST_OPEN_MASKED; // T_OPEN_MASK
                else if (row_act)         state_d = ST_OPEN_FULL;   // T_OPEN_PLAIN
            end
            ST_OPEN_FULL, ST_OPEN_MASKED: begin
                if (!row_act)             state_d = ST_IDLE;        // T_CLOSE
            end
            default:                      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cap_masked = 1'b0;
        cap_plain  = 1'b0;
        close_row  = 1'b0;
        write_ok   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cap_masked = row_act && mask_req;
                cap_plain  = row_act && !mask_req;
            end
            ST_OPEN_FULL, ST_OPEN_MASKED: begin
                close_row = !row_act;
                write_ok  = row_act && wr_en && (|col_sel);
            end
            default: ;
        endcase
    end

    // an open state is only ever reached or kept with the row active
    p_open_needs_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> $past(row_act));

endmodule

// File: rtl/pbw_mask_latch.sv
module pbw_mask_latch #(
    parameter int NUM_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_masked,
    input  logic                 cap_plain,
    input  logic                 close_row,
    input  logic [NUM_BYTES-1:0] par_pins,
    output logic [NUM_BYTES-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mask_q <= '0;
        else if (close_row)  mask_q <= '0;
        else if (cap_masked) mask_q <= par_pins;
        else if (cap_plain)  mask_q <= '1;
    end

    // a plain row cycle must leave every parity bit writable
    p_plain_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_plain |=> (&mask_q));

endmodule

// File: rtl/pbw_lane_merge.sv
module pbw_lane_merge #(
    parameter int NUM_BYTES = 4,
    parameter int LANE_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        write_ok,
    input  logic [NUM_BYTES-1:0]        col_sel,
    input  logic [NUM_BYTES-1:0]        mask_q,
    input  logic [NUM_BYTES*LANE_W-1:0] wdata,
    input  logic [NUM_BYTES*LANE_W-1:0] stored,
    output logic [NUM_BYTES*LANE_W-1:0] merged,
    output logic                        write_stb
);

    localparam int WORD_W  = NUM_BYTES * LANE_W;
    localparam int PAR_BIT = LANE_W - 1;

    logic [WORD_W-1:0] next_word;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        localparam int BASE = b * LANE_W;

        assign next_word[BASE +: PAR_BIT] =
            col_sel[b] ? wdata[BASE +: PAR_BIT] : stored[BASE +: PAR_BIT];
        assign next_word[BASE + PAR_BIT] =
            (col_sel[b] && mask_q[b]) ? wdata[BASE + PAR_BIT] : stored[BASE + PAR_BIT];

        // unselected lane passes through untouched
        p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (write_ok && !col_sel[b]) |=> (merged[BASE +: LANE_W] == $past(stored[BASE +: LANE_W])));

        // masked-off parity bit keeps the stored value
        p_par_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (write_ok && !mask_q[b]) |=> (merged[BASE + PAR_BIT] == $past(stored[BASE + PAR_BIT])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merged    <= '0;
            write_stb <= 1'b0;
        end else begin
            write_stb <= write_ok;
            if (write_ok) merged <= next_word;
        end
    end

endmodule

// File: rtl/par_bitmask_writer.sv
module par_bitmask_writer
    import pbw_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    parameter int LANE_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        row_act,
    input  logic                        mask_req,
    input  logic [NUM_BYTES-1:0]        col_sel,
    input  logic                        wr_en,
    input  logic [NUM_BYTES*LANE_W-1:0] wdata,
    input  logic [NUM_BYTES*LANE_W-1:0] stored,
    output logic [NUM_BYTES*LANE_W-1:0] merged,
    output logic                        write_stb
);

    localparam int PAR_BIT = LANE_W - 1;

    pbw_state_e           state_q;
    logic                 cap_masked, cap_plain, close_row, write_ok;
    logic [NUM_BYTES-1:0] par_pins;
    logic [NUM_BYTES-1:0] mask_q;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_par_tap
        assign par_pins[b] = wdata[b*LANE_W + PAR_BIT];
    end

    pbw_row_fsm #(.NUM_BYTES(NUM_BYTES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_act    (row_act),
        .mask_req   (mask_req),
        .wr_en      (wr_en),
        .col_sel    (col_sel),
        .state_q    (state_q),
        .cap_masked (cap_masked),
        .cap_plain  (cap_plain),
        .close_row  (close_row),
        .write_ok   (write_ok)
    );

    pbw_mask_latch #(.NUM_BYTES(NUM_BYTES)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_masked (cap_masked),
        .cap_plain  (cap_plain),
        .close_row  (close_row),
        .par_pins   (par_pins),
        .mask_q     (mask_q)
    );

    pbw_lane_merge #(.NUM_BYTES(NUM_BYTES), .LANE_W(LANE_W)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .write_ok  (write_ok),
        .col_sel   (col_sel),
        .mask_q    (mask_q),
        .wdata     (wdata),
        .stored    (stored),
        .merged    (merged),
        .write_stb (write_stb)
    );

    // no strobe may follow an idle cycle
    p_idle_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !write_stb);

    // a strobe needs an enabled write with a lane selected
    p_stb_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        write_stb |-> ($past(wr_en) && ($past(col_sel) != '0)));

    // the mask does not move while the row stays open
    p_mask_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && row_act) |=> $stable(mask_q));

    // idle with the row down means no mask remains
    p_mask_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !row_act) |=> (mask_q == '0));

endmodule

// File: tb/tb_par_bitmask_writer.sv
module tb_par_bitmask_writer;

    localparam int NB = 4;
    localparam int LW = 9;
    localparam int WW = NB * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_act = 1'b0;
    logic          mask_req = 1'b0;
    logic [NB-1:0] col_sel = '0;
    logic          wr_en = 1'b0;
    logic [WW-1:0] wdata = '0;
    logic [WW-1:0] stored = '0;
    logic [WW-1:0] merged;
    logic          write_stb;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    par_bitmask_writer #(.NUM_BYTES(NB), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .row_act(row_act), .mask_req(mask_req),
        .col_sel(col_sel), .wr_en(wr_en), .wdata(wdata), .stored(stored),
        .merged(merged), .write_stb(write_stb)
    );

    // reference merge built from R3, R4, R5
    function automatic logic [WW-1:0] ref_merge(input logic [NB-1:0] sel, input logic [NB-1:0] msk,
                                                input logic [WW-1:0] wd, input logic [WW-1:0] st);
        logic [WW-1:0] r;
        r = st;
        for (int b = 0; b < NB; b++) begin
            if (sel[b]) begin
                for (int i = 0; i < LW-1; i++) r[b*LW+i] = wd[b*LW+i];
                if (msk[b]) r[b*LW+LW-1] = wd[b*LW+LW-1];
            end
        end
        return r;
    endfunction

    // parity bits placed on lane tops, data bits set to the inverse
    function automatic logic [WW-1:0] mask_word(input logic [NB-1:0] msk);
        logic [WW-1:0] r;
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < LW-1; i++) r[b*LW+i] = ~msk[b];
            r[b*LW+LW-1] = msk[b];
        end
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic open_row(input logic use_mask, input logic [NB-1:0] msk);
        row_act = 1'b1;
        mask_req = use_mask;
        wdata = mask_word(msk);
        step();
        mask_req = 1'b0;
    endtask

    task automatic close_row();
        row_act = 1'b0;
        wr_en = 1'b0;
        col_sel = '0;
        step();
    endtask

    task automatic do_write(input string req, input logic [NB-1:0] sel, input logic [NB-1:0] msk,
                            input logic [WW-1:0] wd, input logic [WW-1:0] st);
        wr_en = 1'b1; col_sel = sel; wdata = wd; stored = st;
        step();
        chk(req, {{(WW-1){1'b0}}, write_stb}, {{(WW-1){1'b0}}, 1'b1});
        chk(req, merged, ref_merge(sel, msk, wd, st));
        wr_en = 1'b0; col_sel = '0;
        step();
        chk(req, {{(WW-1){1'b0}}, write_stb}, '0);
    endtask

    task automatic t_reset();
        chk("R1 stb", {{(WW-1){1'b0}}, write_stb}, '0);
        chk("R1 merged", merged, '0);
    endtask

    task automatic t_idle_write();
        wr_en = 1'b1; col_sel = '1; wdata = '1; stored = '1;
        step();
        chk("R9 idle stb", {{(WW-1){1'b0}}, write_stb}, '0);
        chk("R9 idle merged", merged, '0);
        wr_en = 1'b0; col_sel = '0;
    endtask

    task automatic t_plain_row();
        open_row(1'b0, '0);
        do_write("R8 plain all parity", '1, '1, '1, '0);
        close_row();
    endtask

    task automatic t_masked_row();
        logic [WW-1:0] held;
        // capture cycle with a write request on the bus: must be ignored (R9)
        held = merged;
        wr_en = 1'b1; col_sel = '1;
        open_row(1'b1, 4'b0101);
        chk("R9 capture stb", {{(WW-1){1'b0}}, write_stb}, '0);
        chk("R9 capture merged", merged, held);
        wr_en = 1'b0; col_sel = '0;
        do_write("R2 R3 R4 first write", '1, 4'b0101, '1, '0);
        do_write("R7 second write", '1, 4'b0101, '0, '1);
        do_write("R5 partial select", 4'b0011, 4'b0101, 36'h5A5A5A5A5, 36'hC3C3C3C3C);
        // wr_en with no lane selected, then lanes without wr_en (R6)
        held = merged;
        wr_en = 1'b1; col_sel = '0; wdata = '0; stored = '0;
        step();
        chk("R6 no select stb", {{(WW-1){1'b0}}, write_stb}, '0);
        chk("R6 no select merged", merged, held);
        wr_en = 1'b0; col_sel = '1;
        step();
        chk("R6 no enable stb", {{(WW-1){1'b0}}, write_stb}, '0);
        chk("R9 hold merged", merged, held);
        col_sel = '0;
        close_row();
    endtask

    task automatic t_zero_mask();
        open_row(1'b1, 4'b0000);
        do_write("R3 zero mask", '1, 4'b0000, '1, '0);
        close_row();
    endtask

    task automatic t_reopen_plain();
        open_row(1'b1, 4'b1000);
        close_row();
        open_row(1'b0, '0);
        do_write("R8 cleared mask", 4'b0110, '1, '1, '0);
        close_row();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_idle_write();
        t_plain_row();
        t_masked_row();
        t_zero_mask();
        t_reopen_plain();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule